// File: doc/BRIEF.md
# Four-to-One I/Q Sample Serializer

This block turns a wide word carrying four 16-bit samples into a stream of one 16-bit sample per fast clock, with one lane for in-phase (I) data and a separate lane for quadrature (Q) data. A single fast clock drives the block. An internal two-bit phase counter divides that clock by four and stands in for the slow fabric clock. `tick_o` marks the last fast cycle of each slow period, and that cycle is the only one in which a word is taken.

Upstream logic places an I word and a Q word on the inputs and raises `load_i` during the tick cycle. Words are packed with the newest sample in the most significant bits, so the serializer sends the least significant sample first. Both lanes then emit their four samples over the next four fast cycles. If no word is offered at a tick, both lanes send zeros for the whole slow period and an underrun flag is raised for that period.

Top module: `iq_ser4`

## Requirements
- R1: After reset is released, `i_samp_o`, `q_samp_o` and `underrun_o` are zero. `tick_o` is high once in every four cycles, and its first high cycle is the fourth cycle after reset release.
- R2: A word is captured only at the clock edge that ends a cycle with `tick_o` high. A `load_i` pulse or a change in the words in any other cycle has no effect on the outputs.
- R3: After a capture, each lane outputs bits [15:0] in the first cycle, then [31:16], then [47:32], then [63:48], one slice per cycle. These are the four cycles after the tick cycle.
- R4: The I lane carries only `i_word_i` and the Q lane carries only `q_word_i`, with identical timing.
- R5: If `load_i` is low in a tick cycle, both lanes output zero and `underrun_o` is high for each of the next four cycles.
- R6: Words loaded at consecutive ticks give a continuous sample stream, with no gap and no repeated or dropped sample.
- R7: A successful load at the tick that follows an underrun period clears `underrun_o` and restores normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Word offered; sampled only in the tick cycle |
| i_word_i | input | 64 | Four I samples, newest in the MSBs |
| q_word_i | input | 64 | Four Q samples, newest in the MSBs |
| tick_o | output | 1 | High in the last fast cycle of each slow period |
| i_samp_o | output | 16 | Serialized I sample |
| q_samp_o | output | 16 | Serialized Q sample |
| underrun_o | output | 1 | Current slow period had no word loaded |

## Verification
The properties assume that upstream logic follows `tick_o`: a word meant for transmission is present and `load_i` is high in the tick cycle. Pulses outside that cycle are allowed, and the block must ignore them. The bench drives its inputs on the falling edge. It uses the tick cycle to present each word, and it deliberately raises `load_i` with unrelated words in the middle of a period to show that they are ignored. It also leaves ticks without a load to exercise the underrun path.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
  localparam int SAMP_W    = 16;
  localparam int RATIO     = 4;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/iq_ser_phase.sv
module iq_ser_phase #(
  parameter int RATIO = 4,
  parameter int PH_W  = $clog2(RATIO)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            wrap_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(RATIO - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (phase_q == LAST)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign wrap_o  = (phase_q == LAST);

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> phase_o == $past(phase_o) + 1'b1); // R6
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> phase_o == '0); // R1
endmodule

// File: rtl/iq_ser_lane.sv
module iq_ser_lane #(
  parameter int SAMP_W = 16,
  parameter int RATIO  = 4,
  parameter int PH_W   = $clog2(RATIO)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PH_W-1:0]          phase_i,
  input  logic                     wrap_i,
  input  logic                     load_i,
  input  logic [SAMP_W*RATIO-1:0]  word_i,
  output logic [SAMP_W-1:0]        samp_o
);
  logic [RATIO-1:0][SAMP_W-1:0] buf_q;

  // oldest sample sits in the low slice, so slice index equals phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     buf_q <= '0;
    else if (wrap_i) buf_q <= load_i ? word_i : '0;
  end

  assign samp_o = buf_q[phase_i];

  AST_HOLD_MID_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(buf_q)); // R2
  AST_FIRST_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && load_i) |=> samp_o == $past(word_i[SAMP_W-1:0])); // R3
  AST_STARVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !load_i) |=> samp_o == '0); // R5
endmodule

// File: rtl/iq_ser4.sv
module iq_ser4
  import iq_ser_pkg::*;
#(
  parameter int SW    = SAMP_W,
  parameter int RT    = RATIO,
  parameter int WORD_W = SW * RT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] i_word_i,
  input  logic [WORD_W-1:0] q_word_i,
  output logic              tick_o,
  output logic [SW-1:0]     i_samp_o,
  output logic [SW-1:0]     q_samp_o,
  output logic              underrun_o
);
  localparam int PH_W = $clog2(RT);

  logic [PH_W-1:0] phase;
  logic            wrap;
  logic            under_q;
  logic [NUM_LANES-1:0][WORD_W-1:0] words;
  logic [NUM_LANES-1:0][SW-1:0]     samps;

  iq_ser_phase #(.RATIO(RT), .PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .wrap_o  (wrap)
  );

  assign words[0] = i_word_i;
  assign words[1] = q_word_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    iq_ser_lane #(.SAMP_W(SW), .RATIO(RT), .PH_W(PH_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .phase_i (phase),
      .wrap_i  (wrap),
      .load_i  (load_i),
      .word_i  (words[g]),
      .samp_o  (samps[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   under_q <= 1'b0;
    else if (wrap) under_q <= !load_i;
  end

  assign tick_o     = wrap;
  assign i_samp_o   = samps[0];
  assign q_samp_o   = samps[1];
  assign underrun_o = under_q;

  AST_TICK_SPARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
  AST_UNDERRUN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(tick_o && !load_i)); // R5
  AST_UNDERRUN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (i_samp_o == '0 && q_samp_o == '0)); // R5
  AST_UNDERRUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && load_i) |=> !underrun_o); // R7
endmodule

// File: tb/sim_iq_ser4.sv
module sim_iq_ser4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [63:0] iw = '0;
  logic [63:0] qw = '0;
  logic        tick;
  logic [15:0] is, qs;
  logic        und;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  iq_ser4 u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .i_word_i(iw), .q_word_i(qw),
    .tick_o(tick), .i_samp_o(is), .q_samp_o(qs), .underrun_o(und)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R1: reset state and tick cadence; ends at the negedge of the first tick cycle
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 samples", {is, qs}, 32'h0);
    chk("R1 underrun", {31'b0, und}, 32'h0);
    chk("R1 tick", {31'b0, tick}, 32'h0);
    for (int n = 1; n <= 3; n++) begin
      @(negedge clk);
      chk("R1 tick cadence", {31'b0, tick}, {31'b0, (n == 3)});
      chk("R1 samples idle", {is, qs}, 32'h0);
    end
  endtask

  // called at a tick negedge; returns at the next tick negedge
  task automatic t_frame(input string req, input logic [63:0] wi, input logic [63:0] wq,
                         input logic ld, input logic glitch);
    logic [15:0] ei, eq;
    chk({req, " tick"}, {31'b0, tick}, 32'h1);
    load = ld; iw = wi; qw = wq;
    @(negedge clk);
    load = 1'b0; iw = ~wi; qw = ~wq;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      ei = ld ? wi[16*k +: 16] : 16'h0;
      eq = ld ? wq[16*k +: 16] : 16'h0;
      chk({req, " I lane"}, {16'h0, is}, {16'h0, ei});
      chk({req, " Q lane"}, {16'h0, qs}, {16'h0, eq});
      chk({req, " underrun"}, {31'b0, und}, {31'b0, !ld});
      if (glitch && k == 1) begin
        load = 1'b1; iw = 64'hDEAD_BEEF_0BAD_F00D; qw = 64'hFACE_CAFE_1234_5678;
      end
      if (glitch && k == 2) load = 1'b0;
    end
  endtask

  initial begin
    t_reset();
    // R3 R4: slice order, lanes independent
    t_frame("R3 R4 pattern A", 64'h4444_3333_2222_1111, 64'hDDDD_CCCC_BBBB_AAAA, 1'b1, 1'b0);
    // R6: back-to-back frames
    t_frame("R6 pattern B", 64'h0123_4567_89AB_CDEF, 64'h8000_7FFF_0001_FFFF, 1'b1, 1'b0);
    // R2: mid-frame load ignored
    t_frame("R2 glitch", 64'h5A5A_A5A5_0F0F_F0F0, 64'h1111_0000_FFFF_8888, 1'b1, 1'b1);
    // R5: underrun
    t_frame("R5 starve", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    t_frame("R5 starve again", 64'h1, 64'h2, 1'b0, 1'b1);
    // R7: recovery
    t_frame("R7 recover", 64'h0004_0003_0002_0001, 64'hF004_F003_F002_F001, 1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule